// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It divides the system clock into a slower conversion clock. On that clock it runs a fixed frame of `RES_W + 3` conversion cycles, which is 13 for the default 10-bit width. The first two cycles initialise the converter. Cycle three drives the sample-and-hold strobe. The remaining cycles each decide one bit of a trial code, which is presented to an external comparator. The comparator reports whether the held input is at least the trial value. The decisions run from the sign bit down to the LSB, and the finished code is two's complement.

When the last decision is made, the result register loads and a sticky completion flag is set in the conversion-clock timing. The flag then passes one further conversion-clock stage and a two-flop system-side stage before it appears at `done_o`. Software clears the flag with a write-one-to-clear pulse, and a new accepted start also clears it.

The channel mux settings are protected by an interlock. The select and the mode can only change while the connection is open and no conversion is pending or running. In differential mode the select names one of four fixed channel pairs. After the enable rises, a settling count of conversion clocks must run out before a frame may begin. A start request made during settling is held pending until then.

Top module: `sar_conv_seq`

## Requirements
- R1: A frame lasts exactly `RES_W+3` conversion clocks. `busy_o` falls on the edge that loads the result, which comes exactly `RES_W+1` conversion clocks after `sh_sample_o` rises.
- R2: `sh_sample_o` is high for exactly one conversion clock, during frame cycle 3. Input changes after that cycle do not affect the result.
- R3: `result_o` is the two's-complement code of the held input. A held value v in [-512, 511] gives `result_o == v`, including -512, 511, 0, -1 and 1. The comparator input `cmp_i` is 1 when the held input is at least `$signed(trial_o)`.
- R4: When `diff_i` is 1, `mux_diff_o` is 1 and `mux_sel_o[2]` is 0, so `mux_sel_o[1:0]` is the pair index. When `diff_i` is 0, `mux_sel_o` equals the 3-bit channel select.
- R5: `mux_on_o` follows `connect_i` only while the block is not busy. Select and mode load only while not busy and while `mux_on_o` is 0. Otherwise they keep their value.
- R6: `done_o` rises exactly `CLK_DIV+2` system clocks after the edge where `busy_o` falls.
- R7: `result_o` resets to 0 and keeps its value until the next completed conversion. This holds during later frames, during aborted frames and while the input changes.
- R8: While `en_i` is 0, the block is idle: `busy_o` and `sh_sample_o` stay 0, `start_i` is ignored, and clearing `en_i` aborts a running frame on the next edge.
- R9: After `en_i` rises, no frame begins until `SETTLE_CYC` conversion clocks have passed. A start given during settling is held pending and then served, with `busy_o` high while it waits.
- R10: `flag_clr_i` clears `done_o` on the next edge, and so does an accepted start. If a clear arrives in the same cycle as a completion, the completion wins and `done_o` still rises.
- R11: `busy_o` is 1 on the cycle after an accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Start request pulse |
| diff_i | input | 1 | Differential mode select |
| chan_sel_i | input | 3 | Channel select, or pair index in differential mode |
| connect_i | input | 1 | Connect the channel mux |
| cmp_i | input | 1 | Comparator decision: held input is at least the trial value |
| flag_clr_i | input | 1 | Write-one-to-clear for the completion flag |
| trial_o | output | 10 | Two's-complement trial code sent to the DAC |
| sh_sample_o | output | 1 | Sample-and-hold strobe, high means sample |
| mux_sel_o | output | 3 | Channel mux selection |
| mux_diff_o | output | 1 | Mux in differential mode |
| mux_on_o | output | 1 | Mux connected |
| busy_o | output | 1 | Start pending or conversion running |
| result_o | output | 10 | Last completed signed result |
| done_o | output | 1 | Sticky completion flag, system-side |

## Verification
The sharpest collision is a write-one-to-clear on the completion flag that lands in the same cycle as the final bit decision. The bench counts clocks from the rise of the sample strobe to place the clear pulse exactly on the result-load edge. It then expects the flag to appear anyway, with the busy drop confirming the alignment. A second run places the clear one cycle later, and there the in-flight flag must be lost. The bench also drops the enable in the middle of a frame, and checks that the held result survives the abort.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);

  p_tick_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int FRAME      = 13,
  parameter int SETTLE_CYC = 8,
  parameter int PH_W       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            en_i,
  input  logic            start_i,
  output logic            busy_o,
  output logic            run_o,
  output logic [PH_W-1:0] phase_o,
  output logic            begin_o,
  output logic            fin_o,
  output logic            accept_o,
  output logic            sh_o
);
  localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(FRAME);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(3);

  seq_state_e      state_q;
  logic [PH_W-1:0] phase_q;
  logic [SET_W-1:0] settle_q;
  logic            sh_q;
  logic            settled;

  assign settled  = (settle_q == '0);
  assign accept_o = (state_q == SEQ_IDLE) && en_i && start_i;
  assign begin_o  = (state_q == SEQ_WAIT) && en_i && tick_i && settled;
  assign fin_o    = (state_q == SEQ_RUN) && en_i && tick_i && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      settle_q <= SET_W'(SETTLE_CYC);
    end else if (tick_i && !settled) begin
      settle_q <= settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      sh_q    <= 1'b0;
    end else if (!en_i) begin
      state_q <= SEQ_IDLE;
      phase_q <= '0;
      sh_q    <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) state_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (begin_o) begin
            state_q <= SEQ_RUN;
            phase_q <= PH_W'(1);
          end
        end
        SEQ_RUN: begin
          if (tick_i) begin
            if (phase_q == PH_LAST) begin
              state_q <= SEQ_IDLE;
              phase_q <= '0;
              sh_q    <= 1'b0;
            end else begin
              phase_q <= phase_q + 1'b1;
              sh_q    <= (phase_q + 1'b1 == PH_SAMPLE);
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != SEQ_IDLE);
  assign run_o   = (state_q == SEQ_RUN);
  assign phase_o = phase_q;
  assign sh_o    = sh_q;

  p_busy_after_start_r11: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> busy_o);

  p_sample_in_cycle3_r2: assert property (@(posedge clk) disable iff (rst)
    sh_q |-> (run_o && phase_q == PH_SAMPLE));

  p_phase_range_r1: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PH_LAST);

  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !busy_o);

  p_settle_first_r9: assert property (@(posedge clk) disable iff (rst)
    begin_o |-> (settle_q == '0));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10,
  parameter int FRAME = 13,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             begin_i,
  input  logic             fin_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam logic [RES_W-1:0] SIGN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [PH_W-1:0]  PH_FIRST_BIT = PH_W'(4);
  localparam logic [PH_W-1:0]  PH_SAMPLE    = PH_W'(3);

  logic [RES_W-1:0] ob_q;
  logic [RES_W-1:0] res_q;
  logic [RES_W-1:0] ob_nxt;
  int               bidx;

  assign bidx = FRAME - int'(phase_i);

  always_comb begin
    ob_nxt = ob_q;
    for (int i = 0; i < RES_W; i++) begin
      if (i == bidx) begin
        ob_nxt[i] = cmp_i;
      end else if (i == bidx - 1) begin
        ob_nxt[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_q <= '0;
    end else if (begin_i) begin
      ob_q <= '0;
    end else if (run_i && tick_i) begin
      if (phase_i == PH_SAMPLE) begin
        ob_q <= SIGN;
      end else if (phase_i >= PH_FIRST_BIT) begin
        ob_q <= ob_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (fin_i) begin
      res_q <= ob_nxt ^ SIGN;
    end
  end

  assign trial_o  = ob_q ^ SIGN;
  assign result_o = res_q;

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fin_i |=> $stable(result_o));

  p_trial_one_hot_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && phase_i == PH_SAMPLE) |=> $onehot0(ob_q));

endmodule

// File: rtl/sar_flag_sync.sv
module sar_flag_sync (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic fin_i,
  input  logic clr_i,
  output logic done_o
);
  logic adc_flag_q;
  logic adc_stage_q;
  logic sys_s1_q;
  logic sys_s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_flag_q <= 1'b0;
    end else if (fin_i) begin
      adc_flag_q <= 1'b1;
    end else if (clr_i) begin
      adc_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      adc_stage_q <= 1'b0;
      sys_s1_q    <= 1'b0;
      sys_s2_q    <= 1'b0;
    end else begin
      if (tick_i) adc_stage_q <= adc_flag_q;
      sys_s1_q <= adc_stage_q;
      sys_s2_q <= sys_s1_q;
    end
  end

  assign done_o = sys_s2_q;

  p_done_via_sync_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(sys_s1_q));

  p_clear_wins_late_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !fin_i) |=> !done_o);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W      = 10,
  parameter int CH_N       = 8,
  parameter int CLK_DIV    = 4,
  parameter int SETTLE_CYC = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic                     start_i,
  input  logic                     diff_i,
  input  logic [$clog2(CH_N)-1:0]  chan_sel_i,
  input  logic                     connect_i,
  input  logic                     cmp_i,
  input  logic                     flag_clr_i,
  output logic [RES_W-1:0]         trial_o,
  output logic                     sh_sample_o,
  output logic [$clog2(CH_N)-1:0]  mux_sel_o,
  output logic                     mux_diff_o,
  output logic                     mux_on_o,
  output logic                     busy_o,
  output logic [RES_W-1:0]         result_o,
  output logic                     done_o
);
  localparam int FRAME = RES_W + 3;
  localparam int PH_W  = $clog2(FRAME + 1);
  localparam int CH_W  = $clog2(CH_N);

  logic            tick;
  logic            run;
  logic            begin_f;
  logic            fin;
  logic            accept;
  logic [PH_W-1:0] phase;
  logic            busy;

  logic            conn_q;
  logic            diff_q;
  logic [CH_W-1:0] sel_q;

  sar_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  sar_frame_ctl #(
    .FRAME      (FRAME),
    .SETTLE_CYC (SETTLE_CYC),
    .PH_W       (PH_W)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .en_i     (en_i),
    .start_i  (start_i),
    .busy_o   (busy),
    .run_o    (run),
    .phase_o  (phase),
    .begin_o  (begin_f),
    .fin_o    (fin),
    .accept_o (accept),
    .sh_o     (sh_sample_o)
  );

  sar_approx_reg #(
    .RES_W (RES_W),
    .FRAME (FRAME),
    .PH_W  (PH_W)
  ) u_sar (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .run_i    (run),
    .begin_i  (begin_f),
    .fin_i    (fin),
    .phase_i  (phase),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .result_o (result_o)
  );

  sar_flag_sync u_flag (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .fin_i  (fin),
    .clr_i  (flag_clr_i | accept),
    .done_o (done_o)
  );

  // Channel interlock: connection frozen while busy, selection frozen while connected.
  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      diff_q <= 1'b0;
      sel_q  <= '0;
    end else if (!busy) begin
      conn_q <= connect_i;
      if (!conn_q) begin
        diff_q <= diff_i;
        sel_q  <= chan_sel_i;
      end
    end
  end

  generate
    if (CH_W > 1) begin : g_pair_mask
      assign mux_sel_o = diff_q ? {1'b0, sel_q[CH_W-2:0]} : sel_q;
    end else begin : g_no_mask
      assign mux_sel_o = sel_q;
    end
  endgenerate

  assign mux_diff_o = diff_q;
  assign mux_on_o   = conn_q;
  assign busy_o     = busy;

  p_conn_frozen_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(mux_on_o));

  p_sel_frozen_conn_r5: assert property (@(posedge clk) disable iff (rst)
    (mux_on_o || busy_o) |=> $stable(mux_sel_o));

endmodule

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;
  localparam int RES_W = 10;
  localparam int D     = 4;
  localparam int S     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, start_i = 1'b0, diff_i = 1'b0, connect_i = 1'b0, flag_clr_i = 1'b0;
  logic [2:0] chan_sel_i = 3'd0;
  logic cmp_i;
  logic [RES_W-1:0] trial_o, result_o;
  logic sh_sample_o, mux_diff_o, mux_on_o, busy_o, done_o;
  logic [2:0] mux_sel_o;

  logic signed [RES_W-1:0] vin = '0;
  logic signed [RES_W-1:0] held = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sar_conv_seq #(.RES_W(RES_W), .CH_N(8), .CLK_DIV(D), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i), .diff_i(diff_i),
    .chan_sel_i(chan_sel_i), .connect_i(connect_i), .cmp_i(cmp_i), .flag_clr_i(flag_clr_i),
    .trial_o(trial_o), .sh_sample_o(sh_sample_o), .mux_sel_o(mux_sel_o), .mux_diff_o(mux_diff_o),
    .mux_on_o(mux_on_o), .busy_o(busy_o), .result_o(result_o), .done_o(done_o)
  );

  // Behavioural sample-and-hold and comparator
  always @(posedge clk) if (sh_sample_o) held <= vin;
  assign cmp_i = (held >= $signed(trial_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int res_val();
    return int'($signed(result_o));
  endfunction

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_sh();
    int t = 0;
    while (!sh_sample_o && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic do_conv(input int v);
    @(negedge clk); vin = RES_W'(v);
    pulse_start();
    chk(busy_o == 1'b1, "R11 busy after start", int'(busy_o), 1);
    chk(done_o == 1'b0, "R10 start clears flag", int'(done_o), 0);
    wait_sh();
    wait_idle();
    chk(res_val() == v, "R3 signed result", res_val(), v);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n, w, m, k, prev;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && mux_on_o == 0 && sh_sample_o == 0, "R8 reset idle",
        int'({busy_o, done_o, mux_on_o, sh_sample_o}), 0);
    chk(result_o == '0, "R7 reset result", res_val(), 0);

    // R4 single-ended select, then connect
    chan_sel_i = 3'd5; diff_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(mux_sel_o == 3'd5 && mux_diff_o == 0, "R4 single-ended select", int'(mux_sel_o), 5);
    connect_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(mux_on_o == 1'b1, "R5 connect when idle", int'(mux_on_o), 1);

    // R9 settling with start pending, then frame timing R1/R2/R6
    vin = 10'sd100;
    en_i = 1'b1; start_i = 1'b1;
    n = 0;
    while (!sh_sample_o && n < 5000) begin
      @(negedge clk); n++;
      if (n == 1) start_i = 1'b0;
      if (n == 2) chk(busy_o == 1'b1, "R9 pending during settle", int'(busy_o), 1);
    end
    chk(n >= (S + 2) * D + 1 && n <= (S + 3) * D, "R9 settle delay", n, (S + 2) * D + 1);
    w = 0;
    while (sh_sample_o && w < 100) begin @(negedge clk); w++; end
    chk(w == D, "R2 sample width", w, D);
    vin = -10'sd300;
    m = 0;
    while (busy_o && m < 1000) begin @(negedge clk); m++; end
    chk(w + m == (RES_W + 1) * D, "R1 frame length", w + m, (RES_W + 1) * D);
    chk(res_val() == 100, "R2 held sample used", res_val(), 100);
    k = 0;
    while (!done_o && k < 1000) begin @(negedge clk); k++; end
    chk(k == D + 2, "R6 flag lag", k, D + 2);

    // R3 corner codes
    do_conv(-512);
    do_conv(511);
    do_conv(0);
    do_conv(-1);
    do_conv(1);

    // R5 interlock during busy and while connected
    @(negedge clk); vin = 10'sd37;
    pulse_start();
    repeat (10) @(negedge clk);
    connect_i = 1'b0; chan_sel_i = 3'd2;
    repeat (5) @(negedge clk);
    chk(mux_on_o == 1'b1 && mux_sel_o == 3'd5, "R5 frozen while busy", int'(mux_sel_o), 5);
    prev = res_val();
    chk(prev == 1, "R7 hold during next frame", prev, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(mux_on_o == 1'b0 && mux_sel_o == 3'd2, "R5 update after idle", int'(mux_sel_o), 2);
    connect_i = 1'b1;
    repeat (2) @(negedge clk);
    chan_sel_i = 3'd6;
    repeat (3) @(negedge clk);
    chk(mux_sel_o == 3'd2, "R5 select ignored while connected", int'(mux_sel_o), 2);
    connect_i = 1'b0; diff_i = 1'b1; chan_sel_i = 3'd7;
    repeat (3) @(negedge clk);
    chk(mux_sel_o == 3'd3 && mux_diff_o == 1'b1, "R4 differential pair", int'(mux_sel_o), 3);
    connect_i = 1'b1;
    repeat (2) @(negedge clk);

    // R7 hold while input changes
    prev = res_val();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); vin = RES_W'($urandom_range(1023));
    end
    chk(res_val() == prev, "R7 hold while idle", res_val(), prev);

    // R10 write-one-to-clear
    do_conv(55);
    repeat (D + 4) @(negedge clk);
    chk(done_o == 1'b1, "R10 flag set", int'(done_o), 1);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    chk(done_o == 1'b0, "R10 w1c clears", int'(done_o), 0);

    // R10 clear in the completion cycle: completion wins
    @(negedge clk); vin = -10'sd77;
    pulse_start();
    wait_sh();
    repeat ((RES_W + 1) * D - 1) @(negedge clk);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    chk(busy_o == 1'b0, "R1 clear aligned with load", int'(busy_o), 0);
    repeat (D + 3) @(negedge clk);
    chk(done_o == 1'b1, "R10 set wins over clear", int'(done_o), 1);

    // R10 clear one cycle after completion: flag lost
    pulse_start();
    wait_sh();
    repeat ((RES_W + 1) * D) @(negedge clk);
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    repeat (D + 4) @(negedge clk);
    chk(done_o == 1'b0, "R10 late clear drops flag", int'(done_o), 0);

    // R3 random
    for (int i = 0; i < 30; i++) do_conv(int'($urandom_range(1023)) - 512);

    // R8 enable low aborts and blocks starts
    prev = res_val();
    @(negedge clk); vin = 10'sd200;
    pulse_start();
    repeat (20) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R8 abort on disable", int'(busy_o), 0);
    pulse_start();
    w = 0;
    for (int i = 0; i < 20 * D; i++) begin
      @(negedge clk);
      if (busy_o || sh_sample_o) w++;
    end
    chk(w == 0, "R8 start ignored when off", w, 0);
    chk(res_val() == prev, "R7 result kept after abort", res_val(), prev);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule